// File: doc/BRIEF.md
# Staggered ADC Conversion Sequencer

This block is the digital scheduler in front of a four-slot analog-to-digital converter. It issues single-cycle start pulses to the converter slots, takes back a done strobe with a data word from each slot, writes every result into a bank of per-channel result registers and raises a conversion-end interrupt. Software chooses one input channel, a conversion time in clock cycles, serial or parallel operation and one-result or four-result buffering. All four settings are captured at the rising edge of the enable input.

In serial operation only slot 0 is used: a new conversion starts as soon as the previous one reports done, and this repeats for as long as the block is enabled. In parallel operation the four slots are started in rotation, a quarter of the conversion time apart, so up to four conversions overlap and a result arrives every quarter period. With one-result buffering every stored result raises the interrupt. With four-result buffering results go to four consecutive result registers, and the interrupt fires only when the fourth one has been stored.

Top module: `adc_stagger_seq`

## Requirements
- R1: One cycle after `en` is first seen high, `slot_start` pulses slot 0. The mode, buffering, channel and `conv_time` inputs are captured on that same clock edge.
- R2: In serial mode (`par_mode`=0 at capture) only bit 0 of `slot_start` is ever set. The next pulse comes in the cycle after `slot_done[0]` is sampled high.
- R3: In parallel mode (`par_mode`=1 at capture) the start pulses recur every `conv_time`/4 cycles and rotate over slots 0, 1, 2, 3, 0 and so on. `conv_time` must be a multiple of 4 and at least 4.
- R4: `slot_start` never has more than one bit set in a cycle.
- R5: With one-result buffering (`buf4_mode`=0), a sampled done writes its data into result register `chan_sel`. In the following cycle that register shows the data and `irq` is high for exactly one cycle.
- R6: With four-result buffering (`buf4_mode`=1), the k-th result since enable (k counted from 0) is written to register (`chan_sel`+k) mod NUM_CH. `irq` pulses only when k mod 4 equals 3, and the count then wraps to 0.
- R7: While `en` is low, `slot_start` is 0 in that same cycle. Results of conversions still in flight are stored but raise no `irq` and do not advance the buffer count.
- R8: Changes to `par_mode`, `buf4_mode`, `chan_sel` or `conv_time` while enabled have no effect until the next rising edge of `en`. That edge also restarts the buffer count and the stagger timer.
- R9: After reset, `slot_start` and `irq` are 0 and every result register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; its rising edge captures the settings |
| par_mode | input | 1 | 1 = parallel staggered operation, 0 = serial |
| buf4_mode | input | 1 | 1 = four-result buffering, 0 = one-result |
| chan_sel | input | CH_W (3) | Selected analog channel / first result register |
| conv_time | input | CT_W (16) | Conversion time in clock cycles, multiple of 4 |
| slot_start | output | SLOTS (4) | One start pulse per converter slot |
| slot_done | input | SLOTS (4) | Done strobes from the slots; lowest set index is taken if several coincide |
| slot_data | input | SLOTS*DATA_W (48) | Result words; slot s at bits [s*DATA_W +: DATA_W] |
| res_flat | output | NUM_CH*DATA_W (96) | Result registers; channel c at bits [c*DATA_W +: DATA_W] |
| irq | output | 1 | Single-cycle conversion-end interrupt |

## Verification
The hardest state to reach from the ports is a conversion that completes after `en` has dropped while the buffer count sits somewhere in the middle of a group. That result must still land in the register picked by the frozen count, but it must raise no interrupt. The bench contains a converter model with a fixed latency and cuts enable at random points in staggered and serial runs, so completions keep arriving after the disable. The settings inputs are also scrambled during enabled runs, so that only the captured settings can explain where each result lands and when `irq` fires.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int SLOTS     = 4;
   localparam int SLOT_W    = 2;
   localparam int BUF_GROUP = 4;

   typedef enum logic {
      MODE_SERIAL   = 1'b0,
      MODE_PARALLEL = 1'b1
   } op_mode_e;

   // index of the lowest set bit; 0 when the vector is empty
   function automatic logic [SLOT_W-1:0] lowest_slot(input logic [SLOTS-1:0] v);
      logic [SLOT_W-1:0] r;
      r = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (v[i]) r = SLOT_W'(i);
      end
      return r;
   endfunction
endpackage

// File: rtl/adc_seq_ctrl.sv
// Enable edge detection and capture of the run settings.
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int CH_W = 3,
   parameter int CT_W = 16,
   parameter int QW   = CT_W - 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            par_mode,
   input  logic            buf4_mode,
   input  logic [CH_W-1:0] chan_sel,
   input  logic [CT_W-1:0] conv_time,
   output logic            arm,
   output op_mode_e        cfg_mode,
   output logic            cfg_buf4,
   output logic [CH_W-1:0] cfg_chan,
   output logic [QW-1:0]   cfg_quarter,
   output logic [QW-1:0]   load_quarter
);
   logic en_q;
   logic [QW-1:0] q_raw;

   assign arm   = en & ~en_q;
   assign q_raw = QW'(conv_time >> 2);
   // a zero quarter would stall the timer; clamp to one cycle
   assign load_quarter = (q_raw == '0) ? QW'(1) : q_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q        <= 1'b0;
         cfg_mode    <= MODE_SERIAL;
         cfg_buf4    <= 1'b0;
         cfg_chan    <= '0;
         cfg_quarter <= QW'(1);
      end else begin
         en_q <= en;
         if (arm) begin
            cfg_mode    <= par_mode ? MODE_PARALLEL : MODE_SERIAL;
            cfg_buf4    <= buf4_mode;
            cfg_chan    <= chan_sel;
            cfg_quarter <= load_quarter;
         end
      end
   end
endmodule

// File: rtl/adc_seq_launch.sv
// Start pulse generation: serial chaining or quarter-period stagger.
module adc_seq_launch
   import adc_seq_pkg::*;
#(
   parameter int QW = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             arm,
   input  op_mode_e         mode,
   input  logic [QW-1:0]    load_quarter,
   input  logic [QW-1:0]    run_quarter,
   input  logic             done0,
   output logic [SLOTS-1:0] slot_start
);
   logic [SLOTS-1:0]  start_q;
   logic [QW-1:0]     timer;
   logic [SLOT_W-1:0] ptr;
   logic [SLOTS-1:0]  serial_next;

   // serial operation only ever restarts slot 0
   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_serial
         if (s == 0) begin : g_lead
            assign serial_next[s] = done0;
         end else begin : g_idle
            assign serial_next[s] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         timer   <= '0;
         ptr     <= '0;
      end else if (!en) begin
         start_q <= '0;
      end else if (arm) begin
         start_q <= SLOTS'(1);
         timer   <= load_quarter - QW'(1);
         ptr     <= SLOT_W'(1);
      end else if (mode == MODE_PARALLEL) begin
         if (timer == '0) begin
            start_q <= SLOTS'(1) << ptr;
            ptr     <= ptr + SLOT_W'(1);
            timer   <= run_quarter - QW'(1);
         end else begin
            start_q <= '0;
            timer   <= timer - QW'(1);
         end
      end else begin
         start_q <= serial_next;
      end
   end

   // dropping enable silences the outputs in the same cycle
   assign slot_start = start_q & {SLOTS{en}};
endmodule

// File: rtl/adc_seq_store.sv
// Result capture, buffer group counting and interrupt generation.
module adc_seq_store
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 12,
   parameter int CH_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic                     arm,
   input  logic                     buf4,
   input  logic [CH_W-1:0]          chan,
   input  logic [SLOTS-1:0]         slot_done,
   input  logic [SLOTS*DATA_W-1:0]  slot_data,
   output logic [NUM_CH*DATA_W-1:0] res_flat,
   output logic                     irq
);
   localparam int CW = $clog2(BUF_GROUP);

   logic              hit;
   logic [SLOT_W-1:0] src;
   logic [DATA_W-1:0] wdata;
   logic [CW-1:0]     cnt;
   logic [CH_W-1:0]   wr_ch;
   logic              group_end;

   assign hit       = |slot_done;
   assign src       = lowest_slot(slot_done);
   assign wdata     = slot_data[src*DATA_W +: DATA_W];
   assign wr_ch     = buf4 ? CH_W'(chan + CH_W'(cnt)) : chan;
   assign group_end = (cnt == CW'(BUF_GROUP - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         irq <= 1'b0;
      end else begin
         irq <= hit & en & (~buf4 | group_end);
         if (arm)
            cnt <= '0;
         else if (hit & en & buf4)
            cnt <= cnt + CW'(1);
      end
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_res
         logic [DATA_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r <= '0;
            else if (hit && wr_ch == CH_W'(c))
               r <= wdata;
         end
         assign res_flat[c*DATA_W +: DATA_W] = r;
      end
   endgenerate
endmodule

// File: rtl/adc_stagger_seq.sv
module adc_stagger_seq
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 12,
   parameter int CT_W   = 16,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int QW    = CT_W - 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic                     par_mode,
   input  logic                     buf4_mode,
   input  logic [CH_W-1:0]          chan_sel,
   input  logic [CT_W-1:0]          conv_time,
   output logic [SLOTS-1:0]         slot_start,
   input  logic [SLOTS-1:0]         slot_done,
   input  logic [SLOTS*DATA_W-1:0]  slot_data,
   output logic [NUM_CH*DATA_W-1:0] res_flat,
   output logic                     irq
);
   generate
      if (NUM_CH < BUF_GROUP || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
         $error("NUM_CH must be a power of two of at least four");
      end
      if (CT_W < 4) begin : g_bad_ct
         $error("CT_W too narrow for a quarter-period timer");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be positive");
      end
   endgenerate

   logic            arm;
   op_mode_e        cfg_mode;
   logic            cfg_buf4;
   logic [CH_W-1:0] cfg_chan;
   logic [QW-1:0]   cfg_quarter;
   logic [QW-1:0]   load_quarter;

   adc_seq_ctrl #(.CH_W(CH_W), .CT_W(CT_W), .QW(QW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .par_mode     (par_mode),
      .buf4_mode    (buf4_mode),
      .chan_sel     (chan_sel),
      .conv_time    (conv_time),
      .arm          (arm),
      .cfg_mode     (cfg_mode),
      .cfg_buf4     (cfg_buf4),
      .cfg_chan     (cfg_chan),
      .cfg_quarter  (cfg_quarter),
      .load_quarter (load_quarter)
   );

   adc_seq_launch #(.QW(QW)) u_launch (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .arm          (arm),
      .mode         (cfg_mode),
      .load_quarter (load_quarter),
      .run_quarter  (cfg_quarter),
      .done0        (slot_done[0]),
      .slot_start   (slot_start)
   );

   adc_seq_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .arm       (arm),
      .buf4      (cfg_buf4),
      .chan      (cfg_chan),
      .slot_done (slot_done),
      .slot_data (slot_data),
      .res_flat  (res_flat),
      .irq       (irq)
   );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
   import adc_seq_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input op_mode_e         cfg_mode,
   input logic             cfg_buf4,
   input logic [SLOTS-1:0] slot_start,
   input logic [SLOTS-1:0] slot_done,
   input logic             irq
);
   a_r4_one_start: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_start));

   a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> slot_start == '0);

   a_r2_serial_slot0: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cfg_mode == MODE_SERIAL) |-> slot_start[SLOTS-1:1] == '0);

   a_r5_irq_after_store: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(slot_done) != '0 && $past(en)));

   a_r6_group_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && cfg_buf4) |=> !irq);
endmodule

bind adc_stagger_seq adc_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .cfg_mode   (cfg_mode),
   .cfg_buf4   (cfg_buf4),
   .slot_start (slot_start),
   .slot_done  (slot_done),
   .irq        (irq)
);

// File: tb/tb_adc_stagger_seq.sv
`timescale 1ns/1ps
module tb_adc_stagger_seq;
   localparam int NCH = 8;
   localparam int DW  = 12;
   localparam int NS  = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          en;
   logic          par_mode;
   logic          buf4_mode;
   logic [2:0]    chan_sel;
   logic [15:0]   conv_time;
   logic [NS-1:0] slot_start;
   logic [NS-1:0] slot_done;
   logic [NS*DW-1:0]  slot_data;
   logic [NCH*DW-1:0] res_flat;
   logic          irq;

   always #4 clk = ~clk;

   adc_stagger_seq dut (
      .clk(clk), .rst_n(rst_n), .en(en), .par_mode(par_mode),
      .buf4_mode(buf4_mode), .chan_sel(chan_sel), .conv_time(conv_time),
      .slot_start(slot_start), .slot_done(slot_done), .slot_data(slot_data),
      .res_flat(res_flat), .irq(irq)
   );

   int n_chk = 0, n_fail = 0, cyc = 0, arm_cyc = 0;
   bit finished = 0, en_prev = 0, scribbled = 0;
   bit b_par, b_buf4;
   int b_chan, b_ct, b_q, b_cnt;
   int rem [NS];
   bit pend_v = 0;
   int pend_slot = 0;
   logic [DW-1:0] pend_d;
   logic [DW-1:0] exp_res [NCH];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, expv);
      end
   endtask

   function automatic int store_index(input bit b4, input int ch, input int k);
      return b4 ? (ch + k) % NCH : ch;
   endfunction

   function automatic logic [NS-1:0] stagger_slot(input int since, input int q);
      if (since % q != 0) return '0;
      return NS'(1) << ((since / q) % NS);
   endfunction

   task automatic tick();
      logic [NS-1:0] exp_start, dn;
      logic [NS*DW-1:0] dd;
      bit exp_irq, arm, res_ok;
      string sreq;
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
         check(slot_start == '0 && irq == 1'b0, "R9", "reset outputs", {slot_start, irq}, 0);
         check(res_flat == '0, "R9", "reset results", res_flat[63:0], 0);
         en_prev = 0; pend_v = 0;
         foreach (rem[s]) rem[s] = 0;
         slot_done = '0;
         return;
      end
      arm = en && !en_prev;
      if (arm) begin
         b_par = par_mode; b_buf4 = buf4_mode; b_chan = chan_sel;
         b_ct = conv_time; b_q = conv_time / 4; b_cnt = 0; arm_cyc = cyc;
      end
      exp_start = '0;
      if (en) begin
         if (arm) exp_start = NS'(1);
         else if (b_par) exp_start = stagger_slot(cyc - arm_cyc, b_q);
         else if (pend_v && pend_slot == 0) exp_start = NS'(1);
      end
      exp_irq = 0;
      if (pend_v) begin
         exp_res[store_index(b_buf4, b_chan, b_cnt)] = pend_d;
         if (en) begin
            if (!b_buf4) exp_irq = 1;
            else begin
               if (b_cnt == 3) exp_irq = 1;
               b_cnt = (b_cnt + 1) % 4;
            end
         end
      end
      sreq = !en ? "R7" : arm ? "R1" : scribbled ? "R8" : b_par ? "R3" : "R2";
      check(slot_start == exp_start, sreq, "slot_start", slot_start, exp_start);
      check($countones(slot_start) <= 1, "R4", "start count", slot_start, 1);
      sreq = (pend_v && !en) ? "R7" : b_buf4 ? "R6" : "R5";
      check(irq == exp_irq, sreq, "irq", irq, exp_irq);
      res_ok = 1;
      for (int c = 0; c < NCH; c++)
         if (res_flat[c*DW +: DW] !== exp_res[c]) res_ok = 0;
      check(res_ok, b_buf4 ? "R6" : "R5", "result bank", res_flat[63:0], 0);
      // converter model: fixed latency of the captured conversion time
      dn = '0; dd = '0;
      for (int s = 0; s < NS; s++) begin
         if (rem[s] > 0) begin
            rem[s]--;
            if (rem[s] == 0) begin
               dn[s] = 1'b1;
               dd[s*DW +: DW] = DW'($urandom);
            end
         end
         if (exp_start[s]) rem[s] = b_ct;
      end
      pend_v = (dn != '0);
      pend_slot = 0;
      for (int s = NS - 1; s >= 0; s--) if (dn[s]) pend_slot = s;
      pend_d = dd[pend_slot*DW +: DW];
      slot_done = dn;
      slot_data = dd;
      en_prev = en;
   endtask

   task automatic run(input bit p, input bit b4, input int ch, input int ct,
                      input int len, input bit scramble);
      par_mode = p; buf4_mode = b4; chan_sel = 3'(ch); conv_time = 16'(ct);
      en = 1'b1;
      for (int i = 0; i < len; i++) begin
         tick();
         if (scramble && ($urandom % 5 == 0)) begin
            par_mode  = 1'($urandom);
            buf4_mode = 1'($urandom);
            chan_sel  = 3'($urandom);
            conv_time = 16'(4 * (1 + $urandom % 8));
            scribbled = 1;
         end
      end
      en = 1'b0;
      for (int i = 0; i < ct + 6; i++) tick();
      scribbled = 0;
   endtask

   initial begin
      void'($urandom(32'd20417));
      rst_n = 1'b0; en = 1'b0; par_mode = 1'b0; buf4_mode = 1'b0;
      chan_sel = '0; conv_time = 16'd8; slot_done = '0; slot_data = '0;
      foreach (exp_res[c]) exp_res[c] = '0;
      b_par = 0; b_buf4 = 0; b_chan = 0; b_ct = 8; b_q = 2; b_cnt = 0;
      repeat (3) tick();
      rst_n = 1'b1;
      repeat (2) tick();
      run(0, 0, 3, 8, 50, 0);    // serial chaining, single buffer
      run(1, 0, 5, 4, 40, 0);    // quarter of one cycle: start every cycle
      run(1, 1, 2, 16, 120, 0);  // staggered, four-result groups
      run(0, 1, 6, 12, 100, 0);  // group wraps past the top channel
      run(1, 1, 1, 32, 45, 0);   // disable with slots in flight mid-group
      run(1, 0, 7, 28, 61, 1);   // settings scrambled while running
      for (int r = 0; r < 16; r++)
         run(1'($urandom), 1'($urandom), $urandom % 8, 4 * (1 + $urandom % 8),
             20 + $urandom % 150, 1'($urandom));
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule